// File: doc/BRIEF.md
# Quad Down-Counting Timer with Coherent Count Capture

The block holds four programmable 16-bit down-counters behind a simple word-addressed register bus. A free-running prescaler divides a 2 MHz clock-enable input by 1, 2, 4 or 8 and produces a one-cycle tick. Every counter whose run bit is set steps down on that tick. A counter that is at zero when a tick arrives loads its reload value instead of stepping down. If that counter's interrupt enable is set, the wrap also raises its pending flag. One interrupt output is the OR of the four pending flags.

Software reads the counts through three count registers. Timers 1 and 2 share one word, and timers 3 and 4 each have their own word. A capture-mode bit chooses how these reads sample the counters. With the bit at 0, each count read takes fresh values for the timers that its word covers. With the bit at 1, only a read of the shared 1/2 word samples the counters, and it samples all four in the same cycle. Later reads of the timer-3 and timer-4 words then return that frozen, mutually consistent set. Pending flags can be cleared by writing 0 to their bits in the status word, or by writing to a per-timer clear word.

Top module: `quad_snap_timer`

Register words (byte offset, accessed only when addr[1:0] is 00):
- 0x00 control: [3:0] run bit for timers 1..4, [7:4] interrupt enable for timers 1..4, [9:8] rate select.
- 0x04 capture mode: bit 0 selects the capture mode, and bits [31:1] are plain storage.
- 0x08 status: [3:0] pending flags for timers 1..4.
- 0x0C count of timers 1 and 2: [15:0] timer 1, [31:16] timer 2.
- 0x10 count of timer 3 and 0x14 count of timer 4, each in [15:0].
- 0x18, 0x1C, 0x20, 0x24: reload values for timers 1..4, in [15:0].
- 0x28, 0x2C, 0x30, 0x34: clear words for timers 1..4, which read as 0.

## Requirements
- R1: After reset, every register word reads 0 and irq is 0.
- R2: The rate select field (control bits [9:8]) makes the tick rate 1/1, 1/2, 1/4 or 1/8 of the ref_en pulses for the codes 00, 01, 10 and 11. Over 16 consecutive ref_en pulses, a running counter steps down 16, 8, 4 or 2 times.
- R3: A write to a reload word sets the stored reload value and also loads the counter with it. On a tick, a running counter that is at zero reloads. On any other tick it decrements by one.
- R4: A counter whose run bit is 0 holds its value across ticks.
- R5: A wrap sets the timer's pending flag only when its interrupt-enable bit is 1. A wrap with the enable at 0 leaves the status at 0.
- R6: Status bits [3:0] show the pending flags of timers 1..4. Several can be set at once, and irq is 1 exactly when any of them is set.
- R7: In a status write, a bit written as 0 clears that flag and a bit written as 1 leaves it unchanged.
- R8: A write to a timer's clear word clears only that timer's flag.
- R9: When a wrap with the interrupt enabled and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: With the capture-mode bit at 0, a read of any count word returns the live counts of the timers that word covers.
- R11: With the capture-mode bit at 1, a read of the 0x0C word samples all four counters at once. Reads of the 0x10 and 0x14 words then return those sampled values, even if the counters have changed since.
- R12: The capture-mode word at 0x04 is fully readable and writable, and its bit 0 selects the capture mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | 2 MHz clock-enable pulse feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle after rd_en |
| irq | output | 1 | Combined interrupt, OR of the pending flags |

## Verification
Read data is registered, so the word for a read issued at one rising edge is checked at the falling edge that follows. Writes, reloads and tick-driven count or flag changes also take effect at one rising edge. Each check runs only after the driver task has returned past that edge. The irq output is combinational from the flags, so it is checked in the same half-cycle as the flag it reflects. The driver keeps ref_en low during bus accesses, except in the collision case. This means each expected count can be worked out from the exact number of pulses applied.

// File: rtl/qst_pkg.sv
// Package: shared widths, register word indices and the control layout
// for the quad snapshot timer. Assumes a 32-bit data bus and word addressing.
package qst_pkg;
    localparam int NT    = 4;      // number of timers
    localparam int CW    = 16;     // counter width
    localparam int DW    = 32;     // bus data width
    localparam int AW    = 6;      // byte address width
    localparam int IW    = AW - 2; // word index width
    localparam int SEL_W = 2;      // rate select width
    localparam int TI_W  = $clog2(NT);

    localparam logic [IW-1:0] IDX_CTRL  = 4'd0;
    localparam logic [IW-1:0] IDX_LMODE = 4'd1;
    localparam logic [IW-1:0] IDX_STAT  = 4'd2;
    localparam logic [IW-1:0] IDX_C12   = 4'd3;
    localparam logic [IW-1:0] IDX_C3    = 4'd4;
    localparam logic [IW-1:0] IDX_C4    = 4'd5;
    localparam logic [IW-1:0] IDX_RLD0  = 4'd6;
    localparam logic [IW-1:0] IDX_CLR0  = 4'd10;

    typedef struct packed {
        logic [SEL_W-1:0] rate;
        logic [NT-1:0]    ien;
        logic [NT-1:0]    run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/qst_prescaler.sv
// Prescaler: divides the incoming clock-enable by 2**sel with a free-running
// phase counter and emits a one-cycle tick. Assumes ref_en is a single-cycle
// strobe; the tick is combinational so counters step on the same edge.
module qst_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PW = (1 << SEL_W) - 1;

    logic [PW-1:0] phase;
    logic [PW-1:0] mask;

    // Advance the phase on every reference pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else if (ref_en) phase <= phase + 1'b1;
    end

    // Mask keeps the low sel bits of the phase.
    always_comb mask = ~({PW{1'b1}} << sel);

    assign tick = ref_en && ((phase & mask) == '0);

    // R2
    divided_tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != '0 && tick) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/qst_channel.sv
// One timer channel: a down-counter with reload register and a pending flag.
// Assumes tick is one cycle wide; a reload write outranks a tick, and a flag
// set outranks a clear in the same cycle.
module qst_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          ien,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          clr,
    output logic [CW-1:0] count,
    output logic [CW-1:0] reload,
    output logic          flag
);
    logic wrap;

    assign wrap = tick && run && (count == '0);

    // Store the reload value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) reload <= '0;
        else if (load) reload <= load_val;
    end

    // Count down on ticks, reload at zero, load on reload writes.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else if (load) count <= load_val;
        else if (tick && run) count <= wrap ? reload : count - 1'b1;
    end

    // Pending flag: set by an enabled wrap, cleared by software, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else flag <= (wrap && ien) || (flag && !clr);
    end

    // R3
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !load) |=> count == $past(reload));
    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));
    // R5
    masked_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |=> !$rose(flag));
    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ien && clr) |=> flag);
endmodule

// File: rtl/quad_snap_timer.sv
// Top: register decode, four timer channels, count capture and read mux.
// Assumes word-aligned accesses (addr[1:0] == 0) and single-cycle strobes;
// read data is registered and valid the cycle after rd_en.
module quad_snap_timer
    import qst_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_en,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    logic [IW-1:0] idx;
    logic          aligned, wr_ok, rd_ok;
    ctrl_t         ctrl;
    logic [DW-1:0] lmode_reg;
    logic          lmode;
    logic          tick;
    logic [NT-1:0] flags, load, clr, cap;
    logic [CW-1:0] cnt    [NT];
    logic [CW-1:0] rld    [NT];
    logic [CW-1:0] snap   [NT];
    logic [CW-1:0] shown  [NT];
    logic [DW-1:0] rd_next;
    logic          rd12, rd3, rd4;
    logic [IW-1:0] rel_rld;

    assign idx     = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign wr_ok   = wr_en && aligned;
    assign rd_ok   = rd_en && aligned;
    assign lmode   = lmode_reg[0];
    assign rd12    = rd_ok && (idx == IDX_C12);
    assign rd3     = rd_ok && (idx == IDX_C3);
    assign rd4     = rd_ok && (idx == IDX_C4);
    assign rel_rld = idx - IDX_RLD0;

    // Control word: run bits, interrupt enables, rate select.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else if (wr_ok && idx == IDX_CTRL) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Capture-mode word, bit 0 active, remaining bits plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n) lmode_reg <= '0;
        else if (wr_ok && idx == IDX_LMODE) lmode_reg <= wdata;
    end

    qst_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_en(ref_en),
        .sel   (ctrl.rate),
        .tick  (tick)
    );

    // Capture strobes: 1/2 word always samples its pair; 3 and 4 depend on mode.
    always_comb begin
        cap[0] = rd12;
        cap[1] = rd12;
        cap[2] = lmode ? rd12 : rd3;
        cap[3] = lmode ? rd12 : rd4;
    end

    for (genvar g = 0; g < NT; g++) begin : g_ch
        assign load[g] = wr_ok && (idx == IW'(IDX_RLD0 + g));
        assign clr[g]  = (wr_ok && idx == IDX_STAT && !wdata[g])
                      || (wr_ok && idx == IW'(IDX_CLR0 + g));

        qst_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .run     (ctrl.run[g]),
            .ien     (ctrl.ien[g]),
            .load    (load[g]),
            .load_val(wdata[CW-1:0]),
            .clr     (clr[g]),
            .count   (cnt[g]),
            .reload  (rld[g]),
            .flag    (flags[g])
        );

        // Hold the sampled count for later reads.
        always_ff @(posedge clk) begin
            if (!rst_n) snap[g] <= '0;
            else if (cap[g]) snap[g] <= cnt[g];
        end

        // A capturing read shows the live count, otherwise the held one.
        assign shown[g] = cap[g] ? cnt[g] : snap[g];
    end

    assign irq = |flags;

    // Read multiplexer for the word addressed this cycle.
    always_comb begin
        rd_next = '0;
        if (idx == IDX_CTRL)       rd_next = DW'(ctrl);
        else if (idx == IDX_LMODE) rd_next = lmode_reg;
        else if (idx == IDX_STAT)  rd_next = DW'(flags);
        else if (idx == IDX_C12)   rd_next = {shown[1], shown[0]};
        else if (idx == IDX_C3)    rd_next = DW'(shown[2]);
        else if (idx == IDX_C4)    rd_next = DW'(shown[3]);
        else if (idx >= IDX_RLD0 && idx < IW'(IDX_RLD0 + NT))
            rd_next = DW'(rld[rel_rld[TI_W-1:0]]);
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_ok) rdata <= rd_next;
    end

    // R10
    live_read_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lmode && rd3) |=> rdata == DW'($past(cnt[2])));
    // R11
    frozen_read_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lmode && rd3) |=> rdata == DW'($past(snap[2])));
    // R11
    frozen_hold_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lmode && !rd12) |=> $stable(snap[3]));
    // R6
    irq_tracks_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctrl.ien != '0));
endmodule

// File: tb/quad_snap_timer_test.sv
module quad_snap_timer_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] A_CTRL = 6'h00, A_LM = 6'h04, A_ST = 6'h08;
    localparam logic [5:0] A_C12 = 6'h0C, A_C3 = 6'h10, A_C4 = 6'h14;

    logic        clk = 1'b0, rst_n = 1'b0, ref_en = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t q[$];

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;

    quad_snap_timer uut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [5:0] a_rld(input int i); return 6'(8'h18 + 4*i); endfunction
    function automatic logic [5:0] a_clr(input int i); return 6'(8'h28 + 4*i); endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Driver: push the expected word, then issue the read.
    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        it.val = e; it.tag = tag;
        @(negedge clk); q.push_back(it); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse_ref(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_en = 1'b1;
            @(negedge clk); ref_en = 1'b0;
        end
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        vectors++;
        if (irq !== e) begin
            miscompares++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
        end
    endtask

    // Monitor: pop and compare the word returned for each read.
    always @(posedge clk) begin
        if (rd_en) begin
            exp_t it;
            @(negedge clk);
            vectors++;
            if (q.size() == 0) begin
                miscompares++;
                $display("FAIL unexpected read actual=%h expected=none", rdata);
            end else begin
                it = q.pop_front();
                if (rdata !== it.val) begin
                    miscompares++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, rdata, it.val);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_CTRL, 32'h0, "R1 ctrl");
        rd(A_LM, 32'h0, "R1 lmode");
        rd(A_ST, 32'h0, "R1 status");
        rd(A_C12, 32'h0, "R1 count12");
        rd(A_C4, 32'h0, "R1 count4");
        chk_irq(1'b0, "R1");
        // R12 capture-mode word read/write
        wr(A_LM, 32'hFFFF_FFFF);
        rd(A_LM, 32'hFFFF_FFFF, "R12 lmode");
        wr(A_LM, 32'h0);
        // R3 reload write loads counter; R10 live reads
        wr(a_rld(0), 100); wr(a_rld(1), 200); wr(a_rld(2), 300); wr(a_rld(3), 400);
        rd(A_C12, {16'd200, 16'd100}, "R10 count12");
        rd(A_C3, 32'd300, "R10 count3");
        rd(A_C4, 32'd400, "R3 count4");
        rd(a_rld(3), 32'd400, "R3 reload4");
        // R3 wrap, R4 hold of stopped timer 2
        wr(a_rld(0), 2);
        wr(A_CTRL, 32'h001);
        pulse_ref(3);
        rd(A_C12, {16'd200, 16'd2}, "R3 wrap reload");
        pulse_ref(2);
        rd(A_C12, {16'd200, 16'd0}, "R4 t2 held");
        // R5 no flag without enable
        rd(A_ST, 32'h0, "R5 masked wrap");
        chk_irq(1'b0, "R5");
        wr(A_CTRL, 32'h011);
        pulse_ref(1);
        rd(A_ST, 32'h1, "R5 enabled wrap");
        chk_irq(1'b1, "R6");
        // R2 rate select
        for (int s = 0; s < 4; s++) begin
            wr(a_rld(0), 1000);
            wr(A_CTRL, 32'h001 | (s << 8));
            pulse_ref(16);
            wr(A_CTRL, 32'h0);
            rd(A_C12, {16'd200, 16'(1000 - (16 >> s))}, "R2 rate");
        end
        // R6 two pending
        wr(a_rld(2), 0);
        wr(A_CTRL, 32'h044);
        pulse_ref(1);
        wr(A_CTRL, 32'h0);
        rd(A_ST, 32'h5, "R6 two flags");
        // R7 write-0 clears, write-1 keeps
        wr(A_ST, 32'hFFFF_FFFE);
        rd(A_ST, 32'h4, "R7 zero clears");
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, 32'h4, "R7 one keeps");
        chk_irq(1'b1, "R6");
        wr(a_clr(2), 32'h0);
        rd(A_ST, 32'h0, "R8 clear t3");
        chk_irq(1'b0, "R6");
        // R8 clear word touches only its timer
        wr(a_rld(0), 0);
        wr(A_CTRL, 32'h055);
        pulse_ref(1);
        wr(A_CTRL, 32'h0);
        rd(A_ST, 32'h5, "R8 both set");
        wr(a_clr(0), 32'h0);
        rd(A_ST, 32'h4, "R8 clear t1 only");
        rd(a_clr(0), 32'h0, "R8 clear word reads 0");
        wr(a_clr(2), 32'h0);
        // R9 set wins over same-cycle clear
        wr(A_CTRL, 32'h011);
        pulse_ref(1);
        @(negedge clk); ref_en = 1'b1; wr_en = 1'b1; addr = a_clr(0); wdata = '0;
        @(negedge clk); ref_en = 1'b0; wr_en = 1'b0;
        rd(A_ST, 32'h1, "R9 set beats clear");
        wr(A_CTRL, 32'h0);
        wr(a_clr(0), 32'h0);
        rd(A_ST, 32'h0, "R9 plain clear");
        // R11 coherent capture
        wr(A_LM, 32'h1);
        wr(a_rld(0), 11); wr(a_rld(1), 22); wr(a_rld(2), 33); wr(a_rld(3), 44);
        rd(A_C12, {16'd22, 16'd11}, "R11 capture");
        wr(a_rld(2), 55); wr(a_rld(3), 66);
        rd(A_C3, 32'd33, "R11 frozen t3");
        rd(A_C4, 32'd44, "R11 frozen t4");
        rd(A_C3, 32'd33, "R11 no relatch");
        rd(A_C12, {16'd22, 16'd11}, "R11 recapture");
        rd(A_C3, 32'd55, "R11 new t3");
        rd(A_C4, 32'd66, "R11 new t4");
        // R10 back to per-word capture
        wr(A_LM, 32'h0);
        wr(a_rld(2), 77); wr(a_rld(3), 88);
        rd(A_C3, 32'd77, "R10 live t3");
        rd(A_C4, 32'd88, "R10 live t4");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            miscompares++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule